// File: doc/BRIEF.md
# Serial Threshold Offset Programming Port

This block holds the two threshold offsets a FIFO uses for its early-warning flags: the almost-empty offset and the almost-full offset. Software or a board controller writes them and reads them back through a four-wire serial port on a dedicated serial clock. The port has a data input with an active-low load enable and a data output with an active-low read enable. The port keeps both offsets and presents them as parallel outputs. The FIFO's comparison logic uses these outputs. Comparing the offsets with the fill level and moving them into the FIFO clock domains is handled elsewhere.

The two offsets form one serial chain of positions. The almost-empty offset fills positions 0 to OFS_W-1, most significant bit first. The almost-full offset fills the positions after it in the same order. Loading and readback each keep their own position. Each position restarts at 0 when its enable is newly asserted. Each position wraps to 0 after the last position of the chain.

Top module: `sop_port`

## Requirements
- R1: While rst_n is low and after it is released, ae_offset and af_offset both equal the parameter value 7 and sout is 0.
- R2: On each rising sclk edge with load_n low, the bit on sin is stored in the current load position and the load position then advances. The first edge of each new load activation writes position 0. Position p < OFS_W is ae_offset bit OFS_W-1-p. Position p >= OFS_W is af_offset bit 2*OFS_W-1-p.
- R3: A load longer than 2*OFS_W bits wraps, and bit number 2*OFS_W of that activation overwrites position 0.
- R4: On a rising edge with load_n high, ae_offset and af_offset do not change.
- R5: On each rising edge with read_n low and load_n high, sout takes the bit at the current read position, in the position order of R2. The read position then advances. sout is registered, so the bit appears after that edge.
- R6: Each new read activation starts at position 0, not where the previous read stopped.
- R7: A read past the last position wraps to position 0.
- R8: After an edge with read_n high, sout is 0.
- R9: After an edge with both enables low, the load takes effect and sout is 0. A read that follows counts as a new activation and starts at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low load enable |
| sin | input | 1 | Serial data in |
| read_n | input | 1 | Active-low readback enable |
| sout | output | 1 | Serial data out, registered |
| ae_offset | output | OFS_W | Almost-empty offset |
| af_offset | output | OFS_W | Almost-full offset |

## Verification
Full-length loads and reads of distinct patterns show whether the bit order and the split between the two offsets are correct. Runs longer than the chain test the wrap. Short runs separated by idle gaps test the restart-from-zero rule. Cycles with both enables low test the load priority. A long pseudo-random mix of enables and data, checked every cycle against a behavioural model, catches position counts that go off by one at the edges of an activation.

// File: rtl/sop_pkg.sv
package sop_pkg;
    typedef enum logic [1:0] {
        SOP_IDLE = 2'd0,
        SOP_LOAD = 2'd1,
        SOP_READ = 2'd2
    } sop_mode_e;
endpackage

// File: rtl/sop_pos_ctr.sv
module sop_pos_ctr #(
    parameter int LEN = 20,
    localparam int PW = (LEN > 1) ? $clog2(LEN) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    output logic [PW-1:0] pos
);
    typedef struct packed {
        logic [PW-1:0] pos;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (!active) begin
            ctr_d.pos = '0;
        end else if (ctr_q.pos == PW'(LEN - 1)) begin
            ctr_d.pos = '0;
        end else begin
            ctr_d.pos = ctr_q.pos + PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctr_q <= '0;
        else        ctr_q <= ctr_d;
    end

    assign pos = ctr_q.pos;
endmodule

// File: rtl/sop_store.sv
module sop_store #(
    parameter int                LEN = 20,
    parameter logic [LEN-1:0]    RST_VAL = '0,
    localparam int               PW = (LEN > 1) ? $clog2(LEN) : 1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [PW-1:0]  wr_pos,
    input  logic           wr_bit,
    input  logic [PW-1:0]  rd_pos,
    output logic           rd_bit,
    output logic [LEN-1:0] chain
);
    typedef struct packed {
        logic [LEN-1:0] bits;
    } store_t;

    store_t st_d, st_q;

    // position p lives at bit LEN-1-p, so position 0 is the chain MSB
    always_comb begin
        st_d = st_q;
        for (int i = 0; i < LEN; i++) begin
            if (wr_en && (wr_pos == PW'(i))) begin
                st_d.bits[LEN-1-i] = wr_bit;
            end
        end
    end

    always_comb begin
        rd_bit = 1'b0;
        for (int i = 0; i < LEN; i++) begin
            if (rd_pos == PW'(i)) begin
                rd_bit = st_q.bits[LEN-1-i];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q.bits <= RST_VAL;
        else        st_q <= st_d;
    end

    assign chain = st_q.bits;
endmodule

// File: rtl/sop_readout.sv
module sop_readout (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_en,
    input  logic bit_in,
    output logic sout
);
    typedef struct packed {
        logic so;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d    = out_q;
        out_d.so = rd_en ? bit_in : 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign sout = out_q.so;
endmodule

// File: rtl/sop_port.sv
module sop_port #(
    parameter int OFS_W     = 10,
    parameter int AE_RESET  = 7,
    parameter int AF_RESET  = 7
) (
    input  logic             sclk,
    input  logic             rst_n,
    input  logic             load_n,
    input  logic             sin,
    input  logic             read_n,
    output logic             sout,
    output logic [OFS_W-1:0] ae_offset,
    output logic [OFS_W-1:0] af_offset
);
    import sop_pkg::*;

    localparam int               TOTAL = 2 * OFS_W;
    localparam int               PW    = $clog2(TOTAL);
    localparam logic [TOTAL-1:0] CHAIN_RST = {OFS_W'(AE_RESET), OFS_W'(AF_RESET)};

    sop_mode_e        mode;
    logic [PW-1:0]    ld_pos, rd_pos;
    logic             rd_bit;
    logic [TOTAL-1:0] chain;

    // load wins when both enables are low
    always_comb begin
        if (!load_n)      mode = SOP_LOAD;
        else if (!read_n) mode = SOP_READ;
        else              mode = SOP_IDLE;
    end

    sop_pos_ctr #(.LEN(TOTAL)) u_ld_ctr (
        .clk    (sclk),
        .rst_n  (rst_n),
        .active (mode == SOP_LOAD),
        .pos    (ld_pos)
    );

    sop_pos_ctr #(.LEN(TOTAL)) u_rd_ctr (
        .clk    (sclk),
        .rst_n  (rst_n),
        .active (mode == SOP_READ),
        .pos    (rd_pos)
    );

    sop_store #(.LEN(TOTAL), .RST_VAL(CHAIN_RST)) u_store (
        .clk    (sclk),
        .rst_n  (rst_n),
        .wr_en  (mode == SOP_LOAD),
        .wr_pos (ld_pos),
        .wr_bit (sin),
        .rd_pos (rd_pos),
        .rd_bit (rd_bit),
        .chain  (chain)
    );

    sop_readout u_out (
        .clk    (sclk),
        .rst_n  (rst_n),
        .rd_en  (mode == SOP_READ),
        .bit_in (rd_bit),
        .sout   (sout)
    );

    assign ae_offset = chain[TOTAL-1 -: OFS_W];
    assign af_offset = chain[OFS_W-1:0];
endmodule

// File: rtl/sop_port_chk.sv
module sop_port_chk #(
    parameter int OFS_W = 10
) (
    input logic             sclk,
    input logic             rst_n,
    input logic             load_n,
    input logic             sin,
    input logic             read_n,
    input logic             sout,
    input logic [OFS_W-1:0] ae_offset,
    input logic [OFS_W-1:0] af_offset
);
    // R4
    hold_when_idle_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        load_n |=> ($stable(ae_offset) && $stable(af_offset)));

    // R2
    one_bit_per_load_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        !load_n |=> ($countones({ae_offset, af_offset} ^ $past({ae_offset, af_offset})) <= 1));

    // R2
    first_load_bit_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (!load_n && $past(load_n)) |=> (ae_offset[OFS_W-1] == $past(sin)));

    // R8
    quiet_out_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        read_n |=> !sout);

    // R9
    load_priority_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (!load_n && !read_n) |=> !sout);

    // R6
    read_restart_chk: assert property (@(posedge sclk) disable iff (!rst_n)
        (!read_n && load_n && ($past(read_n) || !$past(load_n))) |=> (sout == ae_offset[OFS_W-1]));
endmodule

bind sop_port sop_port_chk #(.OFS_W(OFS_W)) u_chk (.*);

// File: tb/tb_sop_port.sv
module tb_sop_port;
    localparam int CLK_PERIOD = 100;
    localparam int W     = 10;
    localparam int TOTAL = 2 * W;

    logic sclk = 1'b0;
    logic rst_n = 1'b0;
    logic load_n = 1'b1;
    logic sin = 1'b0;
    logic read_n = 1'b1;
    logic sout;
    logic [W-1:0] ae_offset, af_offset;

    int n_vec = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int bits [TOTAL];
    int ld_pos = 0;
    int rd_pos = 0;
    int exp_sout = 0;

    always #(CLK_PERIOD/2) sclk = ~sclk;

    sop_port #(.OFS_W(W), .AE_RESET(7), .AF_RESET(7)) dut (
        .sclk      (sclk),
        .rst_n     (rst_n),
        .load_n    (load_n),
        .sin       (sin),
        .read_n    (read_n),
        .sout      (sout),
        .ae_offset (ae_offset),
        .af_offset (af_offset)
    );

    function automatic int exp_word(input int base);
        int v = 0;
        for (int i = 0; i < W; i++) v = (v << 1) | bits[base + i];
        return v;
    endfunction

    task automatic check(input string tag);
        n_vec++;
        if (ae_offset !== W'(exp_word(0))) begin
            n_bad++;
            $display("FAIL %s ae_offset actual %0d expected %0d", tag, ae_offset, exp_word(0));
        end
        n_vec++;
        if (af_offset !== W'(exp_word(W))) begin
            n_bad++;
            $display("FAIL %s af_offset actual %0d expected %0d", tag, af_offset, exp_word(W));
        end
        n_vec++;
        if (sout !== 1'(exp_sout)) begin
            n_bad++;
            $display("FAIL %s sout actual %0b expected %0d", tag, sout, exp_sout);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < TOTAL; i++) bits[i] = 0;
        // value 7 in both offsets, MSB first
        for (int i = W - 3; i < W; i++) begin
            bits[i] = 1;
            bits[W + i] = 1;
        end
        ld_pos = 0;
        rd_pos = 0;
        exp_sout = 0;
    endtask

    task automatic step(input logic l, input logic s, input logic r, input string tag);
        @(negedge sclk);
        load_n = l; sin = s; read_n = r;
        @(posedge sclk);
        if (!l) begin
            bits[ld_pos] = int'(s);
            ld_pos = (ld_pos + 1) % TOTAL;
            rd_pos = 0;
            exp_sout = 0;
        end else begin
            ld_pos = 0;
            if (!r) begin
                exp_sout = bits[rd_pos];
                rd_pos = (rd_pos + 1) % TOTAL;
            end else begin
                rd_pos = 0;
                exp_sout = 0;
            end
        end
        #(CLK_PERIOD/4);
        check(tag);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    endtask

    initial begin
        int lfsr;
        model_reset();
        repeat (3) @(negedge sclk);
        check("R1 in reset");
        @(negedge sclk);
        rst_n = 1'b1;
        #(CLK_PERIOD/4);
        check("R1 after release");

        repeat (3) step(1'b1, 1'b1, 1'b1, "R4 R8 idle");
        for (int i = 0; i < TOTAL + 5; i++) step(1'b1, 1'b0, 1'b0, "R5 R7 default read");
        repeat (2) step(1'b1, 1'b0, 1'b1, "R8 read stop");
        for (int i = 0; i < 6; i++) step(1'b1, 1'b0, 1'b0, "R6 restart");

        for (int i = 0; i < TOTAL; i++) step(1'b0, 1'((i * 5 + 1) % 3 == 0), 1'b1, "R2 full load");
        repeat (3) step(1'b1, 1'b1, 1'b1, "R4 hold");
        for (int i = 0; i < TOTAL + 2; i++) step(1'b1, 1'b0, 1'b0, "R5 R7 readback");

        for (int i = 0; i < TOTAL + 5; i++) step(1'b0, 1'(i % 2), 1'b1, "R3 load wrap");
        step(1'b1, 1'b0, 1'b1, "R4 gap");
        for (int i = 0; i < 4; i++) step(1'b0, 1'b0, 1'b1, "R2 partial restart");
        for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, "R5 partial read");
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b0, "R9 both low");
        for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, "R9 R6 read after");

        lfsr = 32'h1d3a;
        for (int i = 0; i < 400; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) != 0 ? 32'hB400 : 0);
            step(1'((lfsr & 7) == 0), 1'(lfsr >> 3), 1'((lfsr >> 4) % 4 == 0),
                 "R2 R3 R4 R5 R6 R7 R8 R9 mixed");
        end
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (200000) @(posedge sclk);
        if (!done) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual running expected done");
            finish_run();
        end
    end
endmodule